// File: doc/BRIEF.md
# Reserved Instruction Decode Filter

This block sits in the decode stage of a 64-bit integer core that was built without a floating-point unit and without multiprocessor support. It looks at each 32-bit instruction word as it is presented with a valid strobe. It raises a reserved-instruction exception request for any encoding the core cannot carry out. These are all coprocessor-1 arithmetic and transfer operations, the coprocessor-1 loads and stores, and the four load-linked / store-conditional forms.

The memory barrier instruction is harmless on this core, because loads and stores always complete in program order. The filter therefore tags it for conversion to a no-operation and raises no exception. Every other word passes with both tags clear; decoding it is left to the rest of the pipeline. The checked word is forwarded with its tags one cycle later, so the trap is precise. An emulation handler in software can recover the exact offending word from the forwarded copy. The filter keeps no link state: a trapped load-linked leaves nothing behind that could change how a later word is judged.

Top module: `rid_filter`

## Requirements
- R1: After a clock edge with `rst_n` low, `out_valid`, `out_rsvd` and `out_nop` are 0.
- R2: `out_valid` at the clock edge following an edge equals `in_valid` sampled at that edge (one register of latency), and both tags are 0 whenever `out_valid` is 0.
- R3: `out_insn` equals the last word accepted with `in_valid` high, and it holds its value through cycles where `in_valid` is low.
- R4: A valid word whose major opcode (bits 31:26) is 010001 gives `out_rsvd`=1 and `out_nop`=0, whatever its other bits hold.
- R5: A valid word with major opcode 110001, 110101, 111001 or 111101 (coprocessor-1 word/doubleword load/store) gives `out_rsvd`=1 and `out_nop`=0.
- R6: A valid word with major opcode 110000, 110100, 111000 or 111100 (load-linked and store-conditional, word and doubleword) gives `out_rsvd`=1 and `out_nop`=0.
- R7: A valid word with major opcode 000000 and function field (bits 5:0) 001111 gives `out_nop`=1 and `out_rsvd`=0, whatever bits 25:6 hold.
- R8: Every other valid word gives `out_rsvd`=0 and `out_nop`=0. This includes other function codes under opcode 000000, coprocessor 0 and 2 opcodes (010000, 010010), ordinary loads and stores (100011, 101011) and coprocessor-2 memory opcodes (110010, 111010).
- R9: `out_rsvd` and `out_nop` are never 1 in the same cycle.
- R10: The result for a word depends only on that word. A trapped load-linked does not change the result for a following store-conditional or ordinary load, and back-to-back words are each judged on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word to check |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_insn | output | 32 | Forwarded instruction word |
| out_rsvd | output | 1 | Reserved-instruction exception request |
| out_nop | output | 1 | Convert-to-no-operation request |

## Verification
The hardest situation to reach is a stream of back-to-back valid words whose categories alternate. In such a stream a stale tag, or link state left by a trapped load-linked, would show up as a wrong result on the next word. The stimulus drives a new word on every cycle with no idle gap: a load-linked, then an ordinary load, then a store-conditional, then a barrier, then a coprocessor-1 arithmetic word. Each result is checked in the cycle it emerges. Separate cases fill the unused fields of the barrier and coprocessor-1 words with nonzero patterns, so that matching on the wrong bits is exposed.

// File: rtl/rid_pkg.sv
// Package: shared field widths, opcode constants and the result class type
// for the reserved instruction decode filter.
// Assumes a 32-bit instruction word with a 6-bit major opcode at the top
// and a 6-bit function field at the bottom.
package rid_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int SET_N  = 4;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_CP1     = 6'b010001;
    localparam logic [FN_W-1:0]  FN_BARRIER  = 6'b001111;

    // coprocessor-1 memory opcodes (word/doubleword load and store)
    localparam logic [SET_N*OPC_W-1:0] CP1_MEM_SET =
        {6'b110001, 6'b110101, 6'b111001, 6'b111101};

    // linked load / conditional store opcodes (word and doubleword)
    localparam logic [SET_N*OPC_W-1:0] LINK_SET =
        {6'b110000, 6'b110100, 6'b111000, 6'b111100};

    typedef enum logic [1:0] {
        CLS_PASS = 2'd0,
        CLS_RSVD = 2'd1,
        CLS_NOP  = 2'd2
    } rid_cls_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FN_W-1:0]  fn;
    } rid_fields_t;

endpackage

// File: rtl/rid_opset_match.sv
// Module: compares one major opcode against a packed set of constants and
// reports whether any entry matches.
// Assumes SET holds N entries of W bits, entry 0 in the low bits.
module rid_opset_match #(
    parameter int W = 6,
    parameter int N = 4,
    parameter logic [N*W-1:0] SET = '0
) (
    input  logic [W-1:0] opc,
    output logic         hit
);

    logic [N-1:0] eq;

    // one comparator per set entry
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = (opc == SET[i*W +: W]);
    end

    // any comparator firing is a hit
    assign hit = |eq;

endmodule

// File: rtl/rid_classify.sv
// Module: combinational classifier. Splits an instruction word into its
// major opcode and function field and sorts it into pass, reserved or
// convert-to-nop.
// Assumes the trap sets and the barrier encoding are disjoint; traps are
// given priority anyway so a collision could never yield both tags.
module rid_classify
    import rid_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output rid_cls_e          cls
);

    rid_fields_t f;
    logic        hit_cp1_op;
    logic        hit_cp1_mem;
    logic        hit_link;
    logic        hit_barrier;
    logic        trap_any;

    // pull the two decoded fields out of the word
    always_comb begin
        f.opc = insn[INSN_W-1 -: OPC_W];
        f.fn  = insn[FN_W-1:0];
    end

    rid_opset_match #(.W(OPC_W), .N(SET_N), .SET(CP1_MEM_SET)) u_cp1_mem (
        .opc (f.opc),
        .hit (hit_cp1_mem)
    );

    rid_opset_match #(.W(OPC_W), .N(SET_N), .SET(LINK_SET)) u_link (
        .opc (f.opc),
        .hit (hit_link)
    );

    // single-opcode and opcode+function matches
    always_comb begin
        hit_cp1_op  = (f.opc == OPC_CP1);
        hit_barrier = (f.opc == OPC_SPECIAL) && (f.fn == FN_BARRIER);
        trap_any    = hit_cp1_op | hit_cp1_mem | hit_link;
    end

    // priority: trap over nop over pass
    always_comb begin
        if (trap_any)
            cls = CLS_RSVD;
        else if (hit_barrier)
            cls = CLS_NOP;
        else
            cls = CLS_PASS;
    end

endmodule

// File: rtl/rid_out_stage.sv
// Module: output register stage. Captures the valid strobe, the word and
// the two tags on every clock edge.
// Assumes tags are only meaningful with valid; the word register loads only
// on valid so the last accepted word stays visible to a handler.
module rid_out_stage
    import rid_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  rid_cls_e          cls,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output logic              out_rsvd,
    output logic              out_nop
);

    // valid and tag registers, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rsvd  <= 1'b0;
            out_nop   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_rsvd  <= in_valid && (cls == CLS_RSVD);
            out_nop   <= in_valid && (cls == CLS_NOP);
        end
    end

    // word register, loads only on an accepted word
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_insn <= '0;
        else if (in_valid)
            out_insn <= in_insn;
    end

    AST_TAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_rsvd && out_nop)); // R9

    AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rsvd || out_nop) |-> out_valid); // R2

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_WORD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_insn == $past(in_insn))); // R3

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_insn)); // R3

endmodule

// File: rtl/rid_filter.sv
// Module: top of the reserved instruction decode filter. Classifies each
// valid instruction word and forwards it one cycle later with a reserved
// exception tag or a convert-to-nop tag.
// Assumes a core with no floating-point unit and no linked memory
// operations; no link state is kept anywhere in this block.
module rid_filter #(
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output logic              out_rsvd,
    output logic              out_nop
);

    import rid_pkg::*;

    rid_cls_e cls;
    logic [OPC_W-1:0] top_opc;
    logic [FN_W-1:0]  top_fn;

    // fields used by the port-level checks below
    assign top_opc = in_insn[INSN_W-1 -: OPC_W];
    assign top_fn  = in_insn[FN_W-1:0];

    rid_classify #(.INSN_W(INSN_W)) u_cls (
        .insn (in_insn),
        .cls  (cls)
    );

    rid_out_stage #(.INSN_W(INSN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_insn   (in_insn),
        .cls       (cls),
        .out_valid (out_valid),
        .out_insn  (out_insn),
        .out_rsvd  (out_rsvd),
        .out_nop   (out_nop)
    );

    AST_CP1_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && top_opc == 6'b010001) |=> (out_rsvd && !out_nop)); // R4

    AST_CP1_MEM_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && top_opc[5:4] == 2'b11 && top_opc[1:0] == 2'b01
         && top_opc[3] == 1'b0 || in_valid && top_opc[5:4] == 2'b11
         && top_opc[1:0] == 2'b01 && top_opc[3] == 1'b1)
        |=> out_rsvd); // R5

    AST_LINK_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && top_opc[5:4] == 2'b11 && top_opc[1:0] == 2'b00)
        |=> (out_rsvd && !out_nop)); // R6

    AST_BARRIER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && top_opc == 6'b000000 && top_fn == 6'b001111)
        |=> (out_nop && !out_rsvd)); // R7

    AST_LOADSTORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (top_opc == 6'b100011 || top_opc == 6'b101011))
        |=> (!out_rsvd && !out_nop)); // R8

endmodule

// File: tb/sim_rid_filter.sv
`timescale 1ns/1ps
module sim_rid_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_insn;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        out_rsvd;
    logic        out_nop;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rid_filter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_insn   (in_insn),
        .out_valid (out_valid),
        .out_insn  (out_insn),
        .out_rsvd  (out_rsvd),
        .out_nop   (out_nop)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [25:0] rest);
        return {opc, rest};
    endfunction

    // drive a word at a falling edge, check its result one cycle later
    task automatic send_check(input string req, input logic [31:0] w,
                              input logic exp_rsvd, input logic exp_nop);
        in_valid = 1'b1;
        in_insn  = w;
        @(negedge clk);
        check(req, "out_valid", {31'd0, out_valid}, 32'd1);
        check(req, "out_rsvd",  {31'd0, out_rsvd},  {31'd0, exp_rsvd});
        check(req, "out_nop",   {31'd0, out_nop},   {31'd0, exp_nop});
        check(req, "out_insn",  out_insn, w);
    endtask

    task automatic go_idle();
        in_valid = 1'b0;
        in_insn  = 32'hDEAD_BEEF;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; in_insn = mk(6'b010001, 26'h0);
        repeat (3) @(negedge clk);
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "out_rsvd",  {31'd0, out_rsvd},  32'd0);
        check("R1", "out_nop",   {31'd0, out_nop},   32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cp1_ops();
        send_check("R4", mk(6'b010001, 26'h0000000), 1'b1, 1'b0);
        send_check("R4", mk(6'b010001, 26'h3FFFFFF), 1'b1, 1'b0);
        send_check("R4", mk(6'b010001, 26'h200000F), 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_cp1_mem();
        send_check("R5", mk(6'b110001, 26'h1234567), 1'b1, 1'b0);
        send_check("R5", mk(6'b110101, 26'h0ABCDEF), 1'b1, 1'b0);
        send_check("R5", mk(6'b111001, 26'h0000001), 1'b1, 1'b0);
        send_check("R5", mk(6'b111101, 26'h3FFFFFF), 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_link();
        send_check("R6", mk(6'b110000, 26'h0421000), 1'b1, 1'b0);
        send_check("R6", mk(6'b110100, 26'h0421008), 1'b1, 1'b0);
        send_check("R6", mk(6'b111000, 26'h0421000), 1'b1, 1'b0);
        send_check("R6", mk(6'b111100, 26'h0421008), 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_barrier();
        send_check("R7", 32'h0000_000F, 1'b0, 1'b1);
        send_check("R7", {6'b000000, 20'hFFFFF, 6'b001111}, 1'b0, 1'b1);
        send_check("R7", {6'b000000, 20'h0A5C3, 6'b001111}, 1'b0, 1'b1);
        go_idle();
    endtask

    task automatic t_pass();
        send_check("R8", {6'b000000, 20'h0, 6'b001100}, 1'b0, 1'b0);
        send_check("R8", {6'b000000, 20'h0, 6'b001110}, 1'b0, 1'b0);
        send_check("R8", {6'b000000, 20'h0, 6'b101111}, 1'b0, 1'b0);
        send_check("R8", {6'b000001, 20'h0, 6'b001111}, 1'b0, 1'b0);
        send_check("R8", mk(6'b010000, 26'h0), 1'b0, 1'b0);
        send_check("R8", mk(6'b010010, 26'h0), 1'b0, 1'b0);
        send_check("R8", mk(6'b100011, 26'h0421000), 1'b0, 1'b0);
        send_check("R8", mk(6'b101011, 26'h0421000), 1'b0, 1'b0);
        send_check("R8", mk(6'b110010, 26'h0), 1'b0, 1'b0);
        send_check("R8", mk(6'b111010, 26'h0), 1'b0, 1'b0);
        go_idle();
    endtask

    task automatic t_idle_hold();
        logic [31:0] last;
        last = mk(6'b110001, 26'h0000777);
        send_check("R3", last, 1'b1, 1'b0);
        go_idle();
        check("R2", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check("R2", "out_rsvd idle",  {31'd0, out_rsvd},  32'd0);
        check("R3", "out_insn held",  out_insn, last);
        @(negedge clk);
        check("R3", "out_insn held 2", out_insn, last);
        check("R9", "tags idle", {30'd0, out_rsvd, out_nop}, 32'd0);
    endtask

    task automatic t_stream();
        send_check("R10", mk(6'b110000, 26'h0421000), 1'b1, 1'b0);
        send_check("R10", mk(6'b100011, 26'h0421000), 1'b0, 1'b0);
        send_check("R10", mk(6'b111000, 26'h0421000), 1'b1, 1'b0);
        send_check("R10", 32'h0000_000F, 1'b0, 1'b1);
        send_check("R10", mk(6'b010001, 26'h1000000), 1'b1, 1'b0);
        send_check("R10", mk(6'b101011, 26'h0421000), 1'b0, 1'b0);
        send_check("R9", 32'h0000_000F, 1'b0, 1'b1);
        go_idle();
    endtask

    initial begin
        in_valid = 1'b0;
        in_insn  = '0;
        rst_n    = 1'b0;
        @(negedge clk);
        t_reset();
        t_cp1_ops();
        t_cp1_mem();
        t_link();
        t_barrier();
        t_pass();
        t_idle_hold();
        t_stream();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule